// File: doc/BRIEF.md
# ADC Step Sequencer with Dual Result FIFOs

This block schedules conversions for a multi-channel analog-to-digital front end. Software fills a table of numbered steps. Each step's configuration word picks an analog channel, says whether the step runs once or repeats, and names which of two result queues receives its samples. A step-enable mask controls which steps take part. After software sets the run bit, the sequencer walks the enabled steps from the lowest index to the highest. For each step it pulses a start to the converter and waits for the done strobe. It then stores the sample, tagged with the step number, in the chosen queue. After the last enabled step it wraps and begins a new pass.

A step in single-run mode removes its own bit from the enable mask once its result is in. A repeating step keeps its bit and converts on every pass. Several bus masters share the register port: a host processor and two coprocessors. They are served one access per cycle in a fixed order of priority. Read data comes back one cycle after the grant and is tagged with the master that asked for it. This lets each master drain its own queue while the others are busy.

Top module: `adc_step_sequencer`

Word address map: 0 = control (bit 0 = run), 1 = step-enable mask (bit n = step n), 2 = overrun flags (bit 0 = queue 0, bit 1 = queue 1; writing 1 clears a flag), 4 = queue 0 read port, 5 = queue 1 read port, 16 + n = configuration word of step n.

## Requirements
- R1: No conversion starts until the run bit (control bit 0) is 1. Writing configurations and the enable mask alone starts nothing. Every start pulse follows a cycle in which run was 1.
- R2: Within a pass, only steps whose enable bit is set at that moment are converted, in ascending step order. Disabled steps are skipped and cause no conversion. After the highest enabled step, scanning wraps to the lowest.
- R3: Configuration bit 26 routes the step's result: 0 pushes it into queue 0 and 1 pushes it into queue 1.
- R4: A step whose mode field (configuration bits [1:0]) is 00 converts once. Afterwards its enable bit reads back as 0, and it is not converted again.
- R5: A step whose mode field is nonzero keeps its enable bit and is converted again on every later pass.
- R6: The start pulse carries the step's channel from configuration bits [22:19]. Each queue entry reads back as the 12-bit sample in bits [11:0] and the step number in bits [15:12], with the upper bits zero.
- R7: Each queue holds 32 entries. A push into a full queue is dropped, and the entries already held are kept. The drop sets that queue's sticky overrun flag, which stays set until a 1 is written to its bit.
- R8: A read from an empty queue returns zero and does not set an overrun flag.
- R9: With run set and an all-zero enable mask, the sequencer stays idle. It resumes as soon as any enable bit is written to 1.
- R10: Clearing run while a conversion is in flight lets that conversion finish and store its result. After that no further conversion starts.
- R11: Only one master is granted per cycle, and only a requesting one. The host has the highest priority, then coprocessor 0, then coprocessor 1. Read data is valid the cycle after the grant and is tagged with the granted master's index.
- R12: The start is a one-cycle pulse. No new start is issued until the converter has returned done for the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | NUM_MASTERS | Access request per master (bit 0 host, bit 1 coprocessor 0, bit 2 coprocessor 1) |
| m_we | input | NUM_MASTERS | Write (1) or read (0) per master |
| m_addr | input | NUM_MASTERS*ADDR_W | Word address per master, master k in slice k |
| m_wdata | input | NUM_MASTERS*DATA_W | Write data per master, master k in slice k |
| m_gnt | output | NUM_MASTERS | One-hot grant; the access happens at the clock edge that ends the grant cycle |
| rd_valid | output | 1 | Read data valid |
| rd_owner | output | clog2(NUM_MASTERS) | Index of the master the read data belongs to |
| rd_data | output | DATA_W | Read data |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_channel | output | CH_W | Channel for the conversion being started |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | SAMPLE_W | Converter result, valid with conv_done |

## Verification
The bench targets the wrap of the scan pointer across a sparse enable mask. A faulty scan would reorder the steps or convert a skipped one. It also checks that single-run steps clear their enable bit while repeating steps keep theirs. Getting this wrong would leave a step that never repeats or one that never stops. Stopping mid-conversion is checked as well, since a bad implementation loses the in-flight sample or starts one more conversion. Overfilling a queue must keep the oldest 32 entries and raise only that queue's overrun flag. A queue that is read while empty must return zero. Simultaneous requests from all three masters must be served in priority order, each with the correct owner tag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // register word addresses below the configuration window
   localparam int REG_CTRL   = 0;
   localparam int REG_STEPEN = 1;
   localparam int REG_FLAGS  = 2;
   localparam int REG_FIFO0  = 4;
   localparam int REG_FIFO1  = 5;
   // configuration word field positions
   localparam int CFG_MODE_LSB = 0;
   localparam int CFG_CH_LSB   = 19;
   localparam int CFG_SEL_BIT  = 26;

   typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_t;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           push_data,
   input  logic                       pop,
   input  logic                       ovr_clr,
   output logic [WIDTH-1:0]           head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       ovr
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic             empty, full, do_pop, do_push;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovr   <= 1'b0;
      end else begin
         if (do_push) wptr <= wptr + PW'(1);
         if (do_pop)  rptr <= rptr + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
         if (push && !do_push) ovr <= 1'b1;
         else if (ovr_clr)     ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter #(
   parameter int N = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx
);
   generate
      if (N == 1) begin : g_single
         assign gnt = req;
         assign idx = '0;
      end else begin : g_fixed
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !found) begin
                  found  = 1'b1;
                  gnt[i] = 1'b1;
                  idx    = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
   import adc_seq_pkg::*;
#(
   parameter int NUM_STEPS = 16,
   parameter int CH_W      = 4,
   parameter int SAMPLE_W  = 12,
   localparam int TAG_W    = $clog2(NUM_STEPS),
   localparam int ENT_W    = TAG_W + SAMPLE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic [NUM_STEPS-1:0]      step_en,
   input  logic [NUM_STEPS*CH_W-1:0] step_ch,
   input  logic [NUM_STEPS-1:0]      step_sel,
   input  logic [NUM_STEPS-1:0]      step_one,
   output logic                      conv_start,
   output logic [CH_W-1:0]           conv_channel,
   input  logic                      conv_done,
   input  logic [SAMPLE_W-1:0]       conv_data,
   output logic [1:0]                push,
   output logic [ENT_W-1:0]          push_data,
   output logic [NUM_STEPS-1:0]      en_clr
);
   seq_state_t       state;
   logic [TAG_W-1:0] ptr, cur, pick_hi, pick_any, next;
   logic             hit_hi, hit_any, cur_sel, cur_one, finish;

   // first enabled step at or above the pointer, else lowest enabled (wrap)
   always_comb begin
      hit_hi   = 1'b0;
      hit_any  = 1'b0;
      pick_hi  = '0;
      pick_any = '0;
      for (int i = 0; i < NUM_STEPS; i++) begin
         if (step_en[i] && !hit_any) begin
            hit_any  = 1'b1;
            pick_any = TAG_W'(i);
         end
         if (step_en[i] && !hit_hi && (i >= int'(ptr))) begin
            hit_hi  = 1'b1;
            pick_hi = TAG_W'(i);
         end
      end
      next = hit_hi ? pick_hi : pick_any;
   end

   assign finish    = (state == SEQ_WAIT) && conv_done;
   assign push[0]   = finish && !cur_sel;
   assign push[1]   = finish &&  cur_sel;
   assign push_data = {cur, conv_data};

   always_comb begin
      for (int i = 0; i < NUM_STEPS; i++)
         en_clr[i] = finish && cur_one && (cur == TAG_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SEQ_IDLE;
         ptr          <= '0;
         cur          <= '0;
         cur_sel      <= 1'b0;
         cur_one      <= 1'b0;
         conv_start   <= 1'b0;
         conv_channel <= '0;
      end else begin
         conv_start <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (run && hit_any) begin
                  conv_start   <= 1'b1;
                  conv_channel <= step_ch[next*CH_W +: CH_W];
                  cur          <= next;
                  cur_sel      <= step_sel[next];
                  cur_one      <= step_one[next];
                  state        <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               if (conv_done) begin
                  ptr   <= cur + TAG_W'(1);
                  state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
   import adc_seq_pkg::*;
#(
   parameter int NUM_STEPS   = 16,
   parameter int NUM_MASTERS = 3,
   parameter int FIFO_DEPTH  = 32,
   parameter int SAMPLE_W    = 12,
   parameter int CH_W        = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5
) (
   input  logic                                                 clk,
   input  logic                                                 rst_n,
   input  logic [NUM_MASTERS-1:0]                               m_req,
   input  logic [NUM_MASTERS-1:0]                               m_we,
   input  logic [NUM_MASTERS*ADDR_W-1:0]                        m_addr,
   input  logic [NUM_MASTERS*DATA_W-1:0]                        m_wdata,
   output logic [NUM_MASTERS-1:0]                               m_gnt,
   output logic                                                 rd_valid,
   output logic [((NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1)-1:0] rd_owner,
   output logic [DATA_W-1:0]                                    rd_data,
   output logic                                                 conv_start,
   output logic [CH_W-1:0]                                      conv_channel,
   input  logic                                                 conv_done,
   input  logic [SAMPLE_W-1:0]                                  conv_data
);
   localparam int TAG_W = $clog2(NUM_STEPS);
   localparam int ENT_W = TAG_W + SAMPLE_W;
   localparam int MW    = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
   localparam int CW    = $clog2(FIFO_DEPTH) + 1;

   generate
      if (NUM_STEPS < 2)
         $error("sequencer needs at least two steps");
      if (ADDR_W != TAG_W + 1)
         $error("address width must be one bit above the step index width");
      if ((1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH)
         $error("queue depth must be a power of two");
      if (ENT_W > DATA_W || NUM_STEPS > DATA_W || CFG_SEL_BIT >= DATA_W)
         $error("data width too narrow for entries, mask or configuration");
      if (CFG_CH_LSB + CH_W > DATA_W)
         $error("channel field does not fit the configuration word");
   endgenerate

   // ---------------- bus arbitration ----------------
   logic [MW-1:0]     gidx;
   logic              acc, a_we;
   logic [ADDR_W-1:0] a_addr;
   logic [DATA_W-1:0] a_wdata;

   adc_seq_arbiter #(.N(NUM_MASTERS)) u_arb (
      .req (m_req),
      .gnt (m_gnt),
      .idx (gidx)
   );

   assign acc     = |m_req;
   assign a_we    = m_we[gidx];
   assign a_addr  = m_addr[gidx*ADDR_W +: ADDR_W];
   assign a_wdata = m_wdata[gidx*DATA_W +: DATA_W];

   logic             is_cfg;
   logic [TAG_W-1:0] cfg_idx;
   logic             wr_ctrl, wr_en, wr_flags;

   assign is_cfg   = a_addr[ADDR_W-1];
   assign cfg_idx  = a_addr[TAG_W-1:0];
   assign wr_ctrl  = acc && a_we && (a_addr == ADDR_W'(REG_CTRL));
   assign wr_en    = acc && a_we && (a_addr == ADDR_W'(REG_STEPEN));
   assign wr_flags = acc && a_we && (a_addr == ADDR_W'(REG_FLAGS));

   // ---------------- registers ----------------
   logic                 run_q;
   logic [NUM_STEPS-1:0] step_en, en_clr;
   logic [DATA_W-1:0]    cfg [NUM_STEPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         step_en <= '0;
         for (int s = 0; s < NUM_STEPS; s++) cfg[s] <= '0;
      end else begin
         if (wr_ctrl) run_q <= a_wdata[0];
         // a bus write to the mask wins over a same-cycle self-clear
         if (wr_en) step_en <= a_wdata[NUM_STEPS-1:0];
         else       step_en <= step_en & ~en_clr;
         if (acc && a_we && is_cfg) cfg[cfg_idx] <= a_wdata;
      end
   end

   // ---------------- configuration fields ----------------
   logic [NUM_STEPS*CH_W-1:0] step_ch;
   logic [NUM_STEPS-1:0]      step_sel, step_one;

   generate
      for (genvar s = 0; s < NUM_STEPS; s++) begin : g_cfg
         assign step_ch[s*CH_W +: CH_W] = cfg[s][CFG_CH_LSB +: CH_W];
         assign step_sel[s]             = cfg[s][CFG_SEL_BIT];
         assign step_one[s]             = (cfg[s][CFG_MODE_LSB +: 2] == 2'b00);
      end
   endgenerate

   // ---------------- sequencer ----------------
   logic [1:0]       push;
   logic [ENT_W-1:0] push_data;

   adc_seq_engine #(
      .NUM_STEPS (NUM_STEPS),
      .CH_W      (CH_W),
      .SAMPLE_W  (SAMPLE_W)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run_q),
      .step_en      (step_en),
      .step_ch      (step_ch),
      .step_sel     (step_sel),
      .step_one     (step_one),
      .conv_start   (conv_start),
      .conv_channel (conv_channel),
      .conv_done    (conv_done),
      .conv_data    (conv_data),
      .push         (push),
      .push_data    (push_data),
      .en_clr       (en_clr)
   );

   // ---------------- result queues ----------------
   logic [ENT_W-1:0] fifo_head [2];
   logic [1:0]       fifo_ovr;
   logic [2*CW-1:0]  fifo_cnt_flat;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_fifo
         logic pop_k, clr_k;
         assign pop_k = acc && !a_we && (a_addr == ADDR_W'(REG_FIFO0 + k));
         assign clr_k = wr_flags && a_wdata[k];
         adc_seq_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[k]),
            .push_data (push_data),
            .pop       (pop_k),
            .ovr_clr   (clr_k),
            .head      (fifo_head[k]),
            .count     (fifo_cnt_flat[k*CW +: CW]),
            .ovr       (fifo_ovr[k])
         );
      end
   endgenerate

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rmux;

   always_comb begin
      rmux = '0;
      if (is_cfg)                                rmux = cfg[cfg_idx];
      else if (a_addr == ADDR_W'(REG_CTRL))      rmux = DATA_W'(run_q);
      else if (a_addr == ADDR_W'(REG_STEPEN))    rmux = DATA_W'(step_en);
      else if (a_addr == ADDR_W'(REG_FLAGS))     rmux = DATA_W'(fifo_ovr);
      else if (a_addr == ADDR_W'(REG_FIFO0))     rmux = DATA_W'(fifo_head[0]);
      else if (a_addr == ADDR_W'(REG_FIFO1))     rmux = DATA_W'(fifo_head[1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_owner <= '0;
         rd_data  <= '0;
      end else begin
         rd_valid <= acc && !a_we;
         if (acc && !a_we) begin
            rd_owner <= gidx;
            rd_data  <= rmux;
         end
      end
   end
endmodule

// File: rtl/adc_step_sequencer_chk.sv
module adc_step_sequencer_chk #(
   parameter int NUM_MASTERS = 3,
   parameter int FIFO_DEPTH  = 32,
   localparam int CW         = $clog2(FIFO_DEPTH) + 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] m_req,
   input logic [NUM_MASTERS-1:0] m_gnt,
   input logic                   rd_valid,
   input logic                   conv_start,
   input logic                   conv_done,
   input logic                   run,
   input logic [2*CW-1:0]        fill
);
   logic busy;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (conv_start) busy <= 1'b1;
      else if (conv_done)  busy <= 1'b0;
   end

   assert_start_after_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(run));
   assert_fill_bound0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill[CW-1:0] <= CW'(FIFO_DEPTH));
   assert_fill_bound1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill[2*CW-1:CW] <= CW'(FIFO_DEPTH));
   assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_gnt));
   assert_grant_requested_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_gnt & ~m_req) == '0);
   assert_host_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      m_req[0] |-> m_gnt[0]);
   assert_read_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(|m_req));
   assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !conv_start);
endmodule

bind adc_step_sequencer adc_step_sequencer_chk #(
   .NUM_MASTERS (NUM_MASTERS),
   .FIFO_DEPTH  (FIFO_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_req      (m_req),
   .m_gnt      (m_gnt),
   .rd_valid   (rd_valid),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .run        (run_q),
   .fill       (fifo_cnt_flat)
);

// File: tb/adc_step_sequencer_bench.sv
module adc_step_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NM = 3;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int LAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] m_req = '0, m_we = '0;
   logic [NM*AW-1:0] m_addr = '0;
   logic [NM*DW-1:0] m_wdata = '0;
   logic [NM-1:0] m_gnt;
   logic          rd_valid;
   logic [1:0]    rd_owner;
   logic [DW-1:0] rd_data;
   logic          conv_start;
   logic [3:0]    conv_channel;
   logic          conv_done = 1'b0;
   logic [11:0]   conv_data = '0;

   int errors = 0;
   int checks = 0;

   adc_step_sequencer u_adc_step_sequencer (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_gnt(m_gnt), .rd_valid(rd_valid), .rd_owner(rd_owner),
      .rd_data(rd_data), .conv_start(conv_start), .conv_channel(conv_channel),
      .conv_done(conv_done), .conv_data(conv_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // converter model: done LAT cycles after start, sample = {channel, index}
   int         starts = 0;
   int         dones  = 0;
   int         cnt    = 0;
   logic [3:0] pend_ch = '0;
   logic [3:0]  log_ch   [512];
   logic [11:0] log_data [512];

   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (rst_n) begin
         if (conv_start) begin
            pend_ch = conv_channel;
            cnt     = LAT;
            starts++;
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               conv_done <= 1'b1;
               conv_data <= {pend_ch, 8'(dones)};
               log_ch[dones & 511]   = pend_ch;
               log_data[dones & 511] = {pend_ch, 8'(dones)};
               dones++;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_op(input int m, input bit we, input int addr,
                         input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      m_req[m] = 1'b1;
      m_we[m]  = we;
      m_addr[m*AW +: AW]  = addr[AW-1:0];
      m_wdata[m*DW +: DW] = wd;
      #1;
      while (!m_gnt[m]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      m_req[m] = 1'b0;
      rd = rd_data;
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      logic [31:0] dummy;
      bus_op(0, 1'b1, addr, d, dummy);
   endtask

   task automatic rd(input int addr, output logic [31:0] d);
      bus_op(0, 1'b0, addr, 32'h0, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_dones(input int target);
      for (int i = 0; i < 3000 && dones < target; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] cfgw(input int ch, input bit sel, input int mode);
      return (32'(ch) << 19) | (32'(sel) << 26) | 32'(mode & 3);
   endfunction

   task automatic t_reset;
      logic [31:0] v;
      chk("R12 start low after reset", 32'(conv_start), 0);
      rd(0, v);  chk("R1 run bit resets to 0", v, 0);
      rd(1, v);  chk("R4 enable mask resets to 0", v, 0);
      rd(2, v);  chk("R7 overrun flags reset to 0", v, 0);
      rd(4, v);  chk("R8 empty queue 0 reads zero", v, 0);
   endtask

   task automatic t_no_start;
      int sb;
      sb = starts;
      wr(16 + 2, cfgw(3, 0, 1));
      wr(1, 32'h4);
      idle(40);
      chk("R1 no conversion without run", 32'(starts - sb), 0);
      wr(1, 0);
   endtask

   task automatic t_order;
      logic [31:0] v;
      int b;
      b = dones;
      wr(16 + 1, cfgw(9, 0, 0));
      wr(16 + 3, cfgw(10, 1, 0));
      wr(16 + 5, cfgw(11, 0, 0));
      wr(1, 32'h2A);
      wr(0, 1);
      wait_dones(b + 3);
      idle(20);
      wr(0, 0);
      chk("R4 single-run steps convert once", 32'(dones - b), 3);
      chk("R2 first step 1", 32'(log_ch[b & 511]), 9);
      chk("R2 then step 3", 32'(log_ch[(b + 1) & 511]), 10);
      chk("R6 channel field to converter", 32'(log_ch[(b + 2) & 511]), 11);
      rd(1, v);  chk("R4 single-run bits cleared", v, 0);
      rd(4, v);  chk("R3 step 1 in queue 0", v, {16'h0, 4'd1, log_data[b & 511]});
      rd(4, v);  chk("R6 step 5 entry tagged", v, {16'h0, 4'd5, log_data[(b + 2) & 511]});
      rd(5, v);  chk("R3 step 3 in queue 1", v, {16'h0, 4'd3, log_data[(b + 1) & 511]});
      rd(5, v);  chk("R8 empty queue 1 reads zero", v, 0);
      rd(2, v);  chk("R8 empty read sets no flag", v, 0);
   endtask

   task automatic t_continuous;
      logic [31:0] v;
      int b, n, bad;
      b = dones;
      wr(16 + 0, cfgw(2, 0, 2));
      wr(16 + 4, cfgw(6, 1, 0));
      wr(1, 32'h11);
      wr(0, 1);
      wait_dones(b + 6);
      wr(0, 0);
      idle(20);
      n = dones - b;
      chk("R2 pass starts at step 0", 32'(log_ch[b & 511]), 2);
      chk("R2 step 4 second", 32'(log_ch[(b + 1) & 511]), 6);
      bad = 0;
      for (int i = 2; i < n; i++) if (log_ch[(b + i) & 511] != 4'd2) bad++;
      chk("R5 repeating step keeps converting alone", 32'(bad), 0);
      rd(1, v);  chk("R5 repeating step keeps enable", v, 32'h1);
      rd(5, v);  chk("R3 single-run step 4 in queue 1", v, {16'h0, 4'd4, log_data[(b + 1) & 511]});
      bad = 0;
      rd(4, v);
      if (v != {16'h0, 4'd0, log_data[b & 511]}) bad++;
      for (int i = 2; i < n; i++) begin
         rd(4, v);
         if (v != {16'h0, 4'd0, log_data[(b + i) & 511]}) bad++;
      end
      chk("R5 every repeat stored in order", 32'(bad), 0);
      rd(4, v);  chk("R5 queue 0 drained", v, 0);
      wr(1, 0);
   endtask

   task automatic t_idle_resume;
      logic [31:0] v;
      int b;
      b = dones;
      wr(0, 1);
      idle(30);
      chk("R9 idle with empty mask", 32'(dones - b), 0);
      wr(16 + 7, cfgw(12, 0, 0));
      wr(1, 32'h80);
      idle(20);
      chk("R9 resumes on enable", 32'(dones - b), 1);
      chk("R9 resumed step channel", 32'(log_ch[b & 511]), 12);
      rd(4, v);  chk("R9 resumed result stored", v, {16'h0, 4'd7, log_data[b & 511]});
      wr(0, 0);
   endtask

   task automatic t_stop_mid;
      logic [31:0] v;
      int b, sb;
      b = dones;
      sb = starts;
      wr(16 + 9, cfgw(5, 0, 3));
      wr(1, 32'h200);
      wr(0, 1);
      for (int i = 0; i < 100 && starts == sb; i++) @(negedge clk);
      wr(0, 0);
      idle(30);
      chk("R10 no start after stop", 32'(starts - sb), 1);
      chk("R10 in-flight conversion completes", 32'(dones - b), 1);
      rd(4, v);  chk("R10 in-flight result stored", v, {16'h0, 4'd9, log_data[b & 511]});
      rd(4, v);  chk("R10 nothing more stored", v, 0);
      rd(1, v);  chk("R5 stopped repeating step keeps enable", v, 32'h200);
      wr(1, 0);
   endtask

   task automatic t_overrun;
      logic [31:0] v;
      int b, bad;
      b = dones;
      wr(16 + 8, cfgw(1, 1, 1));
      wr(1, 32'h100);
      wr(0, 1);
      wait_dones(b + 35);
      wr(0, 0);
      idle(20);
      rd(2, v);  chk("R7 queue 1 overrun only", v, 32'h2);
      bad = 0;
      for (int i = 0; i < 32; i++) begin
         rd(5, v);
         if (v != {16'h0, 4'd8, log_data[(b + i) & 511]}) bad++;
      end
      chk("R7 oldest 32 entries kept", 32'(bad), 0);
      rd(5, v);  chk("R7 excess pushes dropped", v, 0);
      rd(2, v);  chk("R7 overrun flag sticky", v, 32'h2);
      wr(2, 32'h2);
      rd(2, v);  chk("R7 overrun flag cleared by write", v, 0);
      wr(1, 0);
   endtask

   task automatic t_arb;
      @(negedge clk);
      m_we = '0;
      m_addr = {5'(16 + 8), 5'(16 + 4), 5'(16 + 0)};
      m_req = 3'b111;
      #1 chk("R11 host wins", 32'(m_gnt), 32'b001);
      @(negedge clk);
      chk("R11 host data valid", 32'(rd_valid), 1);
      chk("R11 owner host", 32'(rd_owner), 0);
      chk("R11 host data", rd_data, cfgw(2, 0, 2));
      m_req[0] = 1'b0;
      #1 chk("R11 coprocessor 0 next", 32'(m_gnt), 32'b010);
      @(negedge clk);
      chk("R11 owner coprocessor 0", 32'(rd_owner), 1);
      chk("R11 coprocessor 0 data", rd_data, cfgw(6, 1, 0));
      m_req[1] = 1'b0;
      #1 chk("R11 coprocessor 1 last", 32'(m_gnt), 32'b100);
      @(negedge clk);
      chk("R11 owner coprocessor 1", 32'(rd_owner), 2);
      chk("R11 coprocessor 1 data", rd_data, cfgw(1, 1, 1));
      m_req[2] = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_no_start;
      t_order;
      t_continuous;
      t_idle_resume;
      t_stop_mid;
      t_overrun;
      t_arb;
      idle(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule